// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small reconfigurable logic array. A bank of product terms (the AND plane) is formed from the inputs. A second plane (the OR plane) sums chosen terms into each output. The pattern that fills both planes is held in registers. It is loaded one term per clock through a synchronous write port and can be read back at any time through an index. After loading, the outputs follow the inputs combinationally, with no clock in the evaluation path.

A mode input picks how the OR plane may use the terms. In shared mode every output can take any term, so one term can serve several functions. In grouped mode every output is tied to a fixed block of consecutive terms. Connect bits that point outside that block are ignored. The mode can be switched on the fly without reloading the stored pattern. Typical loads are a BCD-to-Gray converter in grouped mode and a BCD-to-seven-segment decoder in shared mode, which needs nine terms.

Top module: `pla_array`

## Requirements
- R1: Input i of a term is controlled by a 2-bit literal at bits [2i+1:2i] of the term's literal field. Code 01 uses the input true, 10 uses it complemented, 11 leaves it out of the term, and 00 forces the whole term to 0.
- R2: A term whose literals are all 11 evaluates to 1. An output with no connected term evaluates to 0.
- R3: Bit o of a term's connect field joins that term to the OR of output o. When the bit is 0 the term does not affect that output.
- R4: In shared mode (mode = 0) one term may drive any number of outputs at the same time.
- R5: In grouped mode (mode = 1), output o sees only terms o*4 to o*4+3. Connect bits of other terms for that output are ignored.
- R6: In grouped mode, outputs whose index has no term group (index 4 to 7 with the default sizes) read 0.
- R7: At a rising clock edge with wr_en high, the term at wr_idx takes wr_lit and wr_conn. With wr_en low, nothing stored changes.
- R8: rd_lit and rd_conn show the stored fields of the term at rd_idx combinationally.
- R9: Reset sets every literal to 00 and every connect bit to 0, so every output reads 0.
- R10: A change of mode changes the outputs combinationally, with no reload of the stored pattern.
- R11: The array holds a 4-input BCD-to-Gray converter in grouped mode, with no more than 4 terms per output.
- R12: The array holds a BCD-to-seven-segment decoder in shared mode using 9 terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pattern registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one term |
| wr_idx | input | 4 | Index of the term being written |
| wr_lit | input | 8 | Literal field for the written term |
| wr_conn | input | 8 | Output connect field for the written term |
| rd_idx | input | 4 | Index of the term being read back |
| rd_lit | output | 8 | Stored literal field at rd_idx |
| rd_conn | output | 8 | Stored connect field at rd_idx |
| mode | input | 1 | 0 shared terms, 1 fixed term groups |
| in_vec | input | 4 | Logic inputs |
| out_vec | output | 8 | Logic outputs |

## Verification
The assertions assume that wr_en is low while reset is held. They also assume rd_idx is a steady input that is sampled only at clock edges, so a write can be compared with its readback one edge later. The bench changes every input on the falling edge, keeps wr_en low through reset and after each single-cycle write, and moves mode only between writes. Every output check is made after a short settling delay once the inputs have changed.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int DEF_N_IN   = 4;
    localparam int DEF_N_TERM = 16;
    localparam int DEF_N_OUT  = 8;
    localparam int DEF_GRP    = 4;

    typedef enum logic [1:0] {
        LIT_ZERO = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_ANY  = 2'b11
    } lit_code_e;

    typedef enum logic {
        MODE_SHARED  = 1'b0,
        MODE_GROUPED = 1'b1
    } or_mode_e;
endpackage

// File: rtl/pla_store.sv
module pla_store #(
    parameter int N_TERM = 16,
    parameter int LIT_W  = 8,
    parameter int N_OUT  = 8,
    localparam int IDX_W = $clog2(N_TERM)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [LIT_W-1:0]                  wr_lit,
    input  logic [N_OUT-1:0]                  wr_conn,
    output logic [N_TERM-1:0][LIT_W-1:0]      lit_o,
    output logic [N_TERM-1:0][N_OUT-1:0]      conn_o
);
    typedef struct packed {
        logic [N_TERM-1:0][LIT_W-1:0] lit;
        logic [N_TERM-1:0][N_OUT-1:0] conn;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.lit[wr_idx]  = wr_lit;
            st_d.conn[wr_idx] = wr_conn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lit_o  = st_q.lit;
    assign conn_o = st_q.conn;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [N_TERM-1:0][LIT_W-1:0] lit,
    input  logic [N_IN-1:0]              in_vec,
    output logic [N_TERM-1:0]            term_vec
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] factor;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // low code bit admits the true input, high bit the complement
            assign factor[i] = (lit[t][2*i]   &  in_vec[i]) |
                               (lit[t][2*i+1] & ~in_vec[i]);
        end
        assign term_vec[t] = &factor;
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 16,
    parameter int N_OUT  = 8,
    parameter int GRP    = 4,
    localparam int N_GRP = N_TERM / GRP
) (
    input  logic [N_TERM-1:0][N_OUT-1:0] conn,
    input  logic [N_TERM-1:0]            term_vec,
    input  logic                         mode,
    output logic [N_OUT-1:0]             out_vec
);
    import pla_pkg::*;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] column;
        logic [N_TERM-1:0] reach;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign column[t] = conn[t][o];
            if ((t / GRP) == o) begin : g_in
                assign reach[t] = 1'b1;
            end else begin : g_out_of
                assign reach[t] = 1'b0;
            end
        end
        logic shared_sum, grouped_sum;
        assign shared_sum  = |(term_vec & column);
        assign grouped_sum = |(term_vec & column & reach);
        assign out_vec[o]  = (or_mode_e'(mode) == MODE_GROUPED) ? grouped_sum : shared_sum;
    end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN   = pla_pkg::DEF_N_IN,
    parameter int N_TERM = pla_pkg::DEF_N_TERM,
    parameter int N_OUT  = pla_pkg::DEF_N_OUT,
    parameter int GRP    = pla_pkg::DEF_GRP,
    localparam int LIT_W = 2 * N_IN,
    localparam int IDX_W = $clog2(N_TERM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LIT_W-1:0] wr_lit,
    input  logic [N_OUT-1:0] wr_conn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LIT_W-1:0] rd_lit,
    output logic [N_OUT-1:0] rd_conn,
    input  logic             mode,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);
    logic [N_TERM-1:0][LIT_W-1:0] lit;
    logic [N_TERM-1:0][N_OUT-1:0] conn;
    logic [N_TERM-1:0]            term_vec;

    pla_store #(.N_TERM(N_TERM), .LIT_W(LIT_W), .N_OUT(N_OUT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_lit (wr_lit),
        .wr_conn(wr_conn),
        .lit_o  (lit),
        .conn_o (conn)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .lit     (lit),
        .in_vec  (in_vec),
        .term_vec(term_vec)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .GRP(GRP)) u_or (
        .conn    (conn),
        .term_vec(term_vec),
        .mode    (mode),
        .out_vec (out_vec)
    );

    assign rd_lit  = lit[rd_idx];
    assign rd_conn = conn[rd_idx];
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int N_OUT  = 8,
    parameter int GRP    = 4,
    localparam int LIT_W = 2 * N_IN,
    localparam int IDX_W = $clog2(N_TERM),
    localparam int N_GRP = N_TERM / GRP
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [LIT_W-1:0] wr_lit,
    input logic [N_OUT-1:0] wr_conn,
    input logic [IDX_W-1:0] rd_idx,
    input logic [LIT_W-1:0] rd_lit,
    input logic [N_OUT-1:0] rd_conn,
    input logic             mode,
    input logic [N_OUT-1:0] out_vec
);
    logic armed_q;
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (wr_en) wrote_q <= 1'b1;
        end
    end

    p_write_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en) && rd_idx == $past(wr_idx)) |->
            (rd_lit == $past(wr_lit) && rd_conn == $past(wr_conn)));

    p_hold_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(wr_en) && $stable(rd_idx)) |->
            ($stable(rd_lit) && $stable(rd_conn)));

    p_reset_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrote_q |-> (out_vec == '0));

    if (N_OUT > N_GRP) begin : g_nogrp
        p_no_group_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mode |-> (out_vec[N_OUT-1:N_GRP] == '0));
    end
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .GRP(GRP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_lit (wr_lit),
    .wr_conn(wr_conn),
    .rd_idx (rd_idx),
    .rd_lit (rd_lit),
    .rd_conn(rd_conn),
    .mode   (mode),
    .out_vec(out_vec)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_lit = '0;
    logic [7:0] wr_conn = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_lit;
    logic [7:0] rd_conn;
    logic       mode = 1'b0;
    logic [3:0] in_vec = '0;
    logic [7:0] out_vec;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pla_array dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_lit(wr_lit), .wr_conn(wr_conn), .rd_idx(rd_idx),
        .rd_lit(rd_lit), .rd_conn(rd_conn), .mode(mode),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // cube string: s[0] is in_vec[3] ... s[3] is in_vec[0]; '1' true, '0' complement, '-' absent
    function automatic logic [7:0] cube(input string s);
        logic [7:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int i = 3 - k;
            case (s[k])
                "1":     r[2*i +: 2] = 2'b01;
                "0":     r[2*i +: 2] = 2'b10;
                "-":     r[2*i +: 2] = 2'b11;
                default: r[2*i +: 2] = 2'b00;
            endcase
        end
        return r;
    endfunction

    task automatic wr(input int idx, input logic [7:0] lit, input logic [7:0] con);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[3:0]; wr_lit = lit; wr_conn = con;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int t = 0; t < 16; t++) wr(t, 8'h00, 8'h00);
    endtask

    task automatic apply(input logic [3:0] v, input logic m);
        in_vec = v; mode = m;
        #1;
    endtask

    task automatic t_reset();
        for (int m = 0; m < 2; m++)
            for (int v = 0; v < 16; v++) begin
                apply(v[3:0], m[0]);
                check("R9 outputs after reset", out_vec, 8'h00);
            end
        for (int t = 0; t < 16; t++) begin
            rd_idx = t[3:0]; #1;
            check("R9 literal after reset", rd_lit, 8'h00);
            check("R9 connect after reset", rd_conn, 8'h00);
        end
    endtask

    task automatic t_literals();
        clear_all();
        wr(0, cube("10--"), 8'h01);            // A & ~B on output 0
        wr(1, 8'b11_11_11_00, 8'h02);          // in_vec[0] literal forced zero
        for (int v = 0; v < 16; v++) begin
            apply(v[3:0], 1'b0);
            check("R1 true/complement/absent", out_vec[0], (v[3] & ~v[2]));
            check("R1 force-zero code", out_vec[1], 1'b0);
        end
    endtask

    task automatic t_empty_and_full();
        clear_all();
        wr(3, 8'hFF, 8'h02);
        for (int v = 0; v < 16; v += 5) begin
            apply(v[3:0], 1'b0);
            check("R2 all-absent term is one", out_vec[1], 1'b1);
            check("R2 unconnected output is zero", out_vec[2], 1'b0);
            check("R3 connect bit selects output", out_vec, 8'h02);
        end
    endtask

    task automatic t_shared_reuse();
        clear_all();
        wr(6, cube("-1-1"), 8'b1010_0001);
        for (int v = 0; v < 16; v++) begin
            apply(v[3:0], 1'b0);
            check("R4 one term on three outputs", out_vec, (v[2] & v[0]) ? 8'hA1 : 8'h00);
        end
    endtask

    task automatic t_grouped();
        clear_all();
        wr(2, 8'hFF, 8'b0000_0011);   // group 0 term, also points at output 1
        wr(9, 8'hFF, 8'b0100_0000);   // group 2 term pointing at output 6
        wr(13, 8'hFF, 8'b0000_1000);  // group 3 term for output 3
        apply(4'h5, 1'b0);
        check("R4 shared mode sees all", out_vec, 8'h4B);
        apply(4'h5, 1'b1);
        check("R5 grouped ignores foreign terms", out_vec, 8'h09);
        check("R6 ungrouped outputs zero", out_vec[7:4], 4'h0);
        apply(4'h5, 1'b0);
        check("R10 mode back without reload", out_vec, 8'h4B);
    endtask

    task automatic t_write_gate();
        clear_all();
        wr(5, 8'h5A, 8'hC3);
        @(negedge clk);
        wr_idx = 4'd5; wr_lit = 8'h11; wr_conn = 8'h22; wr_en = 1'b0;
        @(negedge clk);
        rd_idx = 4'd5; #1;
        check("R7 write-enable low keeps literal", rd_lit, 8'h5A);
        check("R7 write-enable low keeps connect", rd_conn, 8'hC3);
        rd_idx = 4'd4; #1;
        check("R8 other index unchanged", rd_lit, 8'h00);
        wr(4, 8'h96, 8'h3C);
        rd_idx = 4'd4; #1;
        check("R8 readback literal", rd_lit, 8'h96);
        check("R8 readback connect", rd_conn, 8'h3C);
    endtask

    task automatic t_gray();
        clear_all();
        wr(0, cube("--10"), 8'h01);
        wr(1, cube("--01"), 8'h01);
        wr(4, cube("-10-"), 8'h02);
        wr(5, cube("-01-"), 8'h02);
        wr(8, cube("1---"), 8'h04);
        wr(9, cube("-1--"), 8'h04);
        wr(12, cube("1---"), 8'h08);
        for (int v = 0; v < 10; v++) begin
            logic [3:0] g = v[3:0] ^ (v[3:0] >> 1);
            apply(v[3:0], 1'b1);
            check("R11 Gray code", out_vec, {4'h0, g});
        end
    endtask

    function automatic logic [6:0] seg(input int d);
        case (d)
            0: return 7'b0111111; 1: return 7'b0000110;
            2: return 7'b1011011; 3: return 7'b1001111;
            4: return 7'b1100110; 5: return 7'b1101101;
            6: return 7'b1111101; 7: return 7'b0000111;
            8: return 7'b1111111; default: return 7'b1100111;
        endcase
    endfunction

    task automatic t_seven_seg();
        clear_all();
        wr(0, cube("1---"), 8'b0110_0001);
        wr(1, cube("-110"), 8'b0111_1101);
        wr(2, cube("-0-0"), 8'b0001_1011);
        wr(3, cube("--11"), 8'b0000_0111);
        wr(4, cube("--00"), 8'b0010_0110);
        wr(5, cube("-101"), 8'b0010_1101);
        wr(6, cube("-0-1"), 8'b0000_0110);
        wr(7, cube("-01-"), 8'b0100_1000);
        wr(8, cube("-10-"), 8'b0100_0000);
        for (int d = 0; d < 10; d++) begin
            apply(d[3:0], 1'b0);
            check("R12 seven segment", out_vec, {1'b0, seg(d)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_literals();
        t_empty_and_full();
        t_shared_reuse();
        t_grouped();
        t_write_gate();
        t_gray();
        t_seven_seg();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule